// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Idle Frames

This block turns bytes into asynchronous serial frames on a single output line. A character goes into a one-entry holding buffer, moves into the frame sequencer at a bit boundary, and is shifted out least significant bit first. The frame has one low start bit, an eight-position data field and one high stop bit. When parity is on, the top position of the data field carries the parity of the lower seven data bits instead of data bit 7. An external baud generator supplies a one-cycle tick per bit time, and every line change happens on such a tick.

Besides data, the sequencer can send two special frames. A break holds the line low for a whole frame and then high for one stop bit. Software requests it with a set pulse, and hardware clears the request when the break finishes. An idle frame holds the line high for a whole frame. It is queued when the transmit enable falls and rises again while a frame is in flight. Parity settings are taken only when a frame starts. Flags report an empty holding buffer and a finished transmission, and each flag has its own interrupt enable.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset the line `txd` is 1, `flag_bfe` is 1, `flag_tc` is 1 and `brk_pend` is 0.
- R2: A data frame lasts 10 bit times, one per `baud_tick`. The start bit is 0, then the eight field positions follow, bit 0 first, and the stop bit is 1.
- R3: With `par_en`=1, field position 7 carries a parity bit instead of data bit 7. The bit makes the count of ones in data bits 6..0 plus parity even when `par_odd`=0 and odd when `par_odd`=1. With `par_en`=0, position 7 carries data bit 7.
- R4: `par_en` and `par_odd` are sampled on the tick that starts a frame. A change during a frame affects only later frames.
- R5: A write (`wr_valid`) is accepted only while `flag_bfe`=1, and accepting it clears `flag_bfe`. A write while the buffer is full is ignored. `flag_bfe` returns to 1 on the tick where the buffered byte starts its frame.
- R6: `flag_tc` sets on the tick that ends a stop bit period when the buffer is empty, and it clears when a write is accepted.
- R7: When `tx_en` rises while no frame is running, the next baud tick starts nothing. The earliest frame start is the second tick after the rise.
- R8: A `brk_set` pulse sets `brk_pend`. The break frame drives 10 low bit times and then 1 high bit time. `brk_pend` clears on the tick that ends that high bit. A pending break starts before buffered data.
- R9: If `tx_en` falls and rises again during a frame, an idle frame of 10 high bit times follows that frame. It is sent before any buffered data.
- R10: `irq_bfe` equals `bfe_ie` AND `flag_bfe`, and `irq_tc` equals `tc_ie` AND `flag_tc`.
- R11: A frame in progress finishes even if `tx_en` drops. No frame starts on a tick while `tx_en`=0, and the line stays 1 outside frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmit enable |
| par_en | input | 1 | Parity on/off |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| bfe_ie | input | 1 | Buffer-empty interrupt enable |
| tc_ie | input | 1 | Transmission-complete interrupt enable |
| brk_set | input | 1 | Pulse that requests a break frame |
| brk_pend | output | 1 | Break request still outstanding |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output line |
| flag_bfe | output | 1 | Holding buffer empty |
| flag_tc | output | 1 | Transmission complete |
| irq_bfe | output | 1 | Buffer-empty interrupt |
| irq_tc | output | 1 | Transmission-complete interrupt |

## Verification
On every cycle, the assertions check the following:
- The line is high whenever no frame runs.
- A break keeps the line low until its final position.
- The stop position of data and idle frames is high.
- The bit counter never passes its frame length.
- An accepted write fills the buffer, and a full buffer holds its data.
- `flag_tc` rises only after a frame ends, and `brk_pend` falls only when a break ends.
- No frame starts while the enable guard is armed.

Only the bench scenarios can show the following:
- The bit order and the parity values.
- That parity settings are taken at the frame start and not mid-frame.
- The priority order of idle, break and data.
- The exact tick on which each flag moves.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
    typedef enum logic [1:0] {
        FK_DATA  = 2'd0,
        FK_BREAK = 2'd1,
        FK_IDLE  = 2'd2
    } frame_kind_e;
endpackage

// File: rtl/tx_holdbuf.sv
module tx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              wr_acc
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hb_t;

    hb_t hb_d, hb_q;

    always_comb begin
        hb_d   = hb_q;
        wr_acc = wr_valid && !hb_q.full;
        if (wr_acc) begin
            hb_d.full = 1'b1;
            hb_d.data = wr_data;
        end else if (take) begin
            hb_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hb_q <= '0;
        else        hb_q <= hb_d;
    end

    assign full = hb_q.full;
    assign data = hb_q.data;

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !full) |=> full); // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(data))); // R5
endmodule

// File: rtl/tx_framer.sv
module tx_framer
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              start_ok,
    input  logic              idle_req,
    input  logic              brk_req,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              txd,
    output logic              busy,
    output logic              take,
    output logic              idle_start,
    output logic              frame_done,
    output frame_kind_e       done_kind
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_BRK = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        frame_kind_e           kind;
        logic [CNT_W-1:0]      cnt;
        logic [CNT_W-1:0]      last;
        logic [FRAME_BITS:0]   pat;
        logic                  txd;
    } fr_t;

    fr_t fr_d, fr_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic [DATA_W-1:0] field;
    logic              brk_go;

    always_comb begin
        fr_d       = fr_q;
        take       = 1'b0;
        idle_start = 1'b0;
        frame_done = 1'b0;
        done_kind  = fr_q.kind;
        cnt_nx     = fr_q.cnt + 1'b1;
        brk_go     = brk_req && !(fr_q.busy && fr_q.kind == FK_BREAK);
        field      = buf_data;
        if (par_en) field[DATA_W-1] = (^buf_data[DATA_W-2:0]) ^ par_odd;
        if (baud_tick) begin
            if (fr_q.busy && fr_q.cnt != fr_q.last) begin
                fr_d.cnt = cnt_nx;
                fr_d.txd = fr_q.pat[cnt_nx];
            end else begin
                frame_done = fr_q.busy;
                fr_d.busy  = 1'b0;
                fr_d.txd   = 1'b1;
                fr_d.cnt   = '0;
                if (start_ok) begin
                    if (idle_req) begin
                        fr_d.busy  = 1'b1;
                        fr_d.kind  = FK_IDLE;
                        fr_d.pat   = '1;
                        fr_d.last  = LAST_STD;
                        idle_start = 1'b1;
                    end else if (brk_go) begin
                        fr_d.busy = 1'b1;
                        fr_d.kind = FK_BREAK;
                        fr_d.pat  = {1'b1, {FRAME_BITS{1'b0}}};
                        fr_d.last = LAST_BRK;
                    end else if (buf_full) begin
                        fr_d.busy = 1'b1;
                        fr_d.kind = FK_DATA;
                        fr_d.pat  = {2'b11, field, 1'b0};
                        fr_d.last = LAST_STD;
                        take      = 1'b1;
                    end
                    if (fr_d.busy) fr_d.txd = fr_d.pat[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q      <= '0;
            fr_q.txd  <= 1'b1;
            fr_q.last <= LAST_STD;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign txd  = fr_q.txd;
    assign busy = fr_q.busy;

    AST_LINE_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_q.busy |-> fr_q.txd); // R11
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.cnt <= fr_q.last); // R2
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.busy && fr_q.kind != FK_BREAK && fr_q.cnt == LAST_STD) |-> fr_q.txd); // R2
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.busy && fr_q.kind == FK_BREAK && fr_q.cnt != fr_q.last) |-> !fr_q.txd); // R8
endmodule

// File: rtl/tx_ctl.sv
module tx_ctl
    import serial_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick,
    input  logic        tx_en,
    input  logic        brk_set,
    input  logic        wr_acc,
    input  logic        busy,
    input  logic        frame_done,
    input  frame_kind_e done_kind,
    input  logic        idle_start,
    input  logic        buf_full,
    input  logic        tc_ie,
    output logic        start_ok,
    output logic        idle_req,
    output logic        brk_req,
    output logic        flag_tc,
    output logic        irq_tc
);
    typedef struct packed {
        logic en;
        logic guard;
        logic drop;
        logic idle;
        logic brk;
        logic tc;
    } ct_t;

    ct_t ct_d, ct_q;
    logic en_rise, en_fall;

    always_comb begin
        ct_d    = ct_q;
        en_rise = tx_en && !ct_q.en;
        en_fall = !tx_en && ct_q.en;
        ct_d.en = tx_en;
        if (baud_tick)          ct_d.guard = 1'b0;
        if (en_rise && !busy)   ct_d.guard = 1'b1;
        if (frame_done)         ct_d.drop  = 1'b0;
        if (en_fall && busy)    ct_d.drop  = 1'b1;
        if (en_rise && busy && ct_q.drop) begin
            ct_d.idle = 1'b1;
            ct_d.drop = 1'b0;
        end
        if (idle_start)         ct_d.idle  = 1'b0;
        if (frame_done && done_kind == FK_BREAK) ct_d.brk = 1'b0;
        if (brk_set)            ct_d.brk   = 1'b1;
        if (frame_done && !buf_full) ct_d.tc = 1'b1;
        if (wr_acc)             ct_d.tc    = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q    <= '0;
            ct_q.tc <= 1'b1;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign start_ok = tx_en && !ct_q.guard;
    assign idle_req = ct_q.idle;
    assign brk_req  = ct_q.brk;
    assign flag_tc  = ct_q.tc;
    assign irq_tc   = tc_ie && ct_q.tc;

    AST_GUARD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.guard && !busy) |=> !busy); // R7
    AST_TC_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ct_q.tc) |-> $past(frame_done)); // R6
    AST_BRK_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ct_q.brk) |-> $past(frame_done && done_kind == FK_BREAK)); // R8
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              bfe_ie,
    input  logic              tc_ie,
    input  logic              brk_set,
    output logic              brk_pend,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              flag_bfe,
    output logic              flag_tc,
    output logic              irq_bfe,
    output logic              irq_tc
);
    logic              buf_full, take, wr_acc;
    logic [DATA_W-1:0] buf_data;
    logic              start_ok, idle_req, brk_req;
    logic              busy, idle_start, frame_done;
    frame_kind_e       done_kind;

    tx_holdbuf #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .full     (buf_full),
        .data     (buf_data),
        .wr_acc   (wr_acc)
    );

    tx_framer #(.DATA_W(DATA_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .start_ok   (start_ok),
        .idle_req   (idle_req),
        .brk_req    (brk_req),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .txd        (txd),
        .busy       (busy),
        .take       (take),
        .idle_start (idle_start),
        .frame_done (frame_done),
        .done_kind  (done_kind)
    );

    tx_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .tx_en      (tx_en),
        .brk_set    (brk_set),
        .wr_acc     (wr_acc),
        .busy       (busy),
        .frame_done (frame_done),
        .done_kind  (done_kind),
        .idle_start (idle_start),
        .buf_full   (buf_full),
        .tc_ie      (tc_ie),
        .start_ok   (start_ok),
        .idle_req   (idle_req),
        .brk_req    (brk_req),
        .flag_tc    (flag_tc),
        .irq_tc     (irq_tc)
    );

    assign flag_bfe = !buf_full;
    assign irq_bfe  = bfe_ie && !buf_full;
    assign brk_pend = brk_req;
endmodule

// File: tb/test_serial_tx_engine.sv
module test_serial_tx_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0, tx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       bfe_ie = 1'b0, tc_ie = 1'b0, brk_set = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       brk_pend, txd, flag_bfe, flag_tc, irq_bfe, irq_tc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_tx_engine i_serial_tx_engine (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .par_en(par_en), .par_odd(par_odd), .bfe_ie(bfe_ie), .tc_ie(tc_ie),
        .brk_set(brk_set), .brk_pend(brk_pend), .wr_valid(wr_valid),
        .wr_data(wr_data), .txd(txd), .flag_bfe(flag_bfe), .flag_tc(flag_tc),
        .irq_bfe(irq_bfe), .irq_tc(irq_tc)
    );

    // {par_en, par_odd, data, expected field}
    localparam logic [17:0] VEC [7] = '{
        {1'b0, 1'b0, 8'hA5, 8'hA5},
        {1'b0, 1'b0, 8'h80, 8'h80},
        {1'b1, 1'b0, 8'h01, 8'h81},
        {1'b1, 1'b0, 8'h55, 8'h55},
        {1'b1, 1'b1, 8'hFF, 8'h7F},
        {1'b1, 1'b1, 8'h00, 8'h80},
        {1'b1, 1'b0, 8'h3C, 8'h3C}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
        @(negedge clk) wr_valid = 1'b0;
    endtask

    task automatic grab(input int first, input int n, inout logic [10:0] bits);
        for (int i = first; i < first + n; i++) begin
            tick();
            bits[i] = txd;
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        logic [10:0] b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", txd, 1);
        chk("R1 bfe", flag_bfe, 1);
        chk("R1 tc", flag_tc, 1);
        chk("R1 brk", brk_pend, 0);
        // R10 interrupt gating
        chk("R10 irq off", {irq_bfe, irq_tc}, 2'b00);
        bfe_ie = 1'b1; tc_ie = 1'b1;
        @(negedge clk);
        chk("R10 irq on", {irq_bfe, irq_tc}, 2'b11);
        bfe_ie = 1'b0; tc_ie = 1'b0;

        // R5/R6/R11/R7: buffered byte, disabled, then guarded enable
        wr(8'hC3);
        chk("R5 bfe clears", flag_bfe, 0);
        chk("R6 tc clears", flag_tc, 0);
        tick(); tick();
        chk("R11 no start disabled", {txd, flag_bfe}, 2'b10);
        wr(8'h11); // ignored: buffer full
        @(negedge clk) tx_en = 1'b1;
        tick();
        chk("R7 guard tick", {txd, flag_bfe}, 2'b10);
        b = '1;
        grab(0, 1, b);
        chk("R5 loaded at start", flag_bfe, 1);
        grab(1, 9, b);
        chk("R2 frame C3", b[9:0], {1'b1, 8'hC3, 1'b0});
        tick();
        chk("R6 tc at end", flag_tc, 1);
        b = '0;
        grab(0, 10, b);
        chk("R5 full-write ignored", b[9:0], 10'h3FF);

        // Vector table: R2/R3
        for (int v = 0; v < 7; v++) begin
            @(negedge clk) begin par_en = VEC[v][17]; par_odd = VEC[v][16]; end
            wr(VEC[v][15:8]);
            b = '1;
            grab(0, 10, b);
            chk("R3 vector frame", b[9:0], {1'b1, VEC[v][7:0], 1'b0});
            tick();
            chk("R6 vector tc", flag_tc, 1);
        end

        // R4 parity sampled at frame start
        @(negedge clk) begin par_en = 1'b1; par_odd = 1'b0; end
        wr(8'h01);
        b = '1;
        grab(0, 1, b);
        @(negedge clk) par_odd = 1'b1;
        grab(1, 9, b);
        chk("R4 old parity kept", b[9:0], {1'b1, 8'h81, 1'b0});
        tick();
        wr(8'h01);
        grab(0, 10, b);
        chk("R4 new parity used", b[9:0], {1'b1, 8'h01, 1'b0});
        tick();
        @(negedge clk) par_en = 1'b0;

        // R8 break before buffered data
        @(negedge clk) brk_set = 1'b1;
        @(negedge clk) brk_set = 1'b0;
        chk("R8 pend set", brk_pend, 1);
        wr(8'hF0);
        b = '1;
        grab(0, 11, b);
        chk("R8 break pattern", b, {1'b1, 10'b0});
        chk("R8 pend held", brk_pend, 1);
        b = '1;
        grab(0, 1, b);
        chk("R8 pend cleared", brk_pend, 0);
        grab(1, 9, b);
        chk("R8 data after break", b[9:0], {1'b1, 8'hF0, 1'b0});
        tick();

        // R9 idle insertion, R11 frame completes while disabled
        wr(8'h3A);
        b = '1;
        grab(0, 5, b);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        @(negedge clk) tx_en = 1'b1;
        wr(8'h5C);
        grab(5, 5, b);
        chk("R11 frame completes", b[9:0], {1'b1, 8'h3A, 1'b0});
        b = '0;
        grab(0, 10, b);
        chk("R9 idle high", b[9:0], 10'h3FF);
        chk("R9 data held", flag_bfe, 0);
        b = '1;
        grab(0, 10, b);
        chk("R9 data after idle", b[9:0], {1'b1, 8'h5C, 1'b0});
        tick();
        @(negedge clk) begin tc_ie = 1'b1; bfe_ie = 1'b0; end
        @(negedge clk);
        chk("R10 tc irq", {irq_bfe, irq_tc}, 2'b01);
        report();
    end
endmodule